// File: doc/BRIEF.md
# Four-Mode Serial Port with Ninth-Bit Address Filtering

This block is a full-duplex serial port. Four frame formats share one engine: a clocked shift mode, an 8-bit asynchronous mode and two 9-bit asynchronous modes. A control/status byte selects the mode, holds the receive enable, the ninth transmit bit, the last received ninth or stop bit and the two event flags. A data byte port is split in two. A write to it loads the transmitter and starts a frame. A read of it returns a separate receive buffer, so a second frame can arrive while the first one waits to be read.

In the asynchronous modes the line is sampled sixteen times per bit. Each bit is decided by a two-of-three vote on the samples in the middle of the bit. A filter option lets a receiver ignore every 9-bit frame whose ninth bit is 0. On a multi-drop bus this means only address frames raise the receive flag. In mode 1 the same option rejects frames that have a bad stop bit. The shift mode drives the shift clock on the transmit pin and moves data in or out on the receive pin. A variable-rate tick enters from outside. The fixed rates are divided down from the system clock inside the block.

Top module: `sport_engine`

## Requirements
- R1: After reset the control byte reads 0x00, txd_o and rxd_o are 1, rxd_oe_o is 0 and irq_o is 0. Control byte fields: [7:6] mode (00 shift, 01 8-bit async, 10 9-bit async at fixed rate, 11 9-bit async at variable rate), [5] filter, [4] receive enable, [3] ninth transmit bit, [2] received ninth/stop bit, [1] transmit flag, [0] receive flag.
- R2: In mode 01 a data write sends ten bits on txd_o: 0, eight data bits LSB first, then 1. Each bit lasts 16 sample ticks. A sample tick is every baud_tick_i when smod_i is 1, and every second baud_tick_i when smod_i is 0.
- R3: In modes 10 and 11 a frame is eleven bits: 0, eight data bits LSB first, control bit 3, then 1.
- R4: In mode 10 a bit lasts 64 clocks with smod_i 0 and 32 clocks with smod_i 1, whatever baud_tick_i does.
- R5: The transmit flag is set when the stop bit starts (mode 0: when the eighth bit ends). irq_o is 1 whenever either flag is set. The flags stay set until they are written with 0.
- R6: In mode 01 a received frame loads the data into the receive buffer and the stop bit into bit 2, and sets the receive flag at mid-stop-bit.
- R7: In mode 01 with the filter set, a frame whose stop bit is 0 leaves the buffer, bit 2 and the receive flag unchanged.
- R8: In modes 10 and 11 bit 2 takes the received ninth bit and the stop bit value is ignored. With the filter set, a frame whose ninth bit is 0 leaves the buffer, bit 2 and the receive flag unchanged.
- R9: Each asynchronous bit is decided by a majority of three samples taken mid-bit. A start bit that votes 1 is dropped, and the receiver waits for the next falling edge.
- R10: With receive enable clear, no frame is received in any mode.
- R11: A frame that completes while the receive flag is still set is lost. The buffer keeps the earlier byte.
- R12: In mode 00 a data write shifts eight bits LSB first out on rxd_o with rxd_oe_o high. Each bit lasts 12 clocks, and txd_o is low for the first 6 of them and high for the last 6.
- R13: In mode 00, when receive enable is 1 and the receive flag is 0, the block starts eight shift clocks on txd_o. It samples rxd_i as each clock rises, then sets the receive flag and stops.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write value |
| ctl_o | output | 8 | Control byte readback |
| dat_we_i | input | 1 | Data write strobe; starts a transmission |
| dat_wdata_i | input | 8 | Byte to transmit |
| dat_o | output | 8 | Receive buffer |
| smod_i | input | 1 | Rate doubling select |
| baud_tick_i | input | 1 | One-cycle rate tick for modes 01 and 11 |
| rxd_i | input | 1 | Receive pin input |
| rxd_o | output | 1 | Receive pin output value (mode 00 transmit) |
| rxd_oe_o | output | 1 | Receive pin output enable |
| txd_o | output | 1 | Transmit data, or the shift clock in mode 00 |
| irq_o | output | 1 | Either event flag set |

## Verification
The bench builds the block with its default dividers: 12 clocks per shift bit and 64 clocks per bit at the slow fixed rate. baud_tick_i is held high, so a variable-rate bit lasts 16 clocks with rate doubling and 32 without. These short, exact bit periods let the bench predict every mid-bit sample point arithmetically. It sweeps several byte patterns through every mode and both filter settings. It also places a one-cycle glitch on the centre sample, to tell a three-sample vote apart from a single sample.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    MD_SHIFT  = 2'b00,
    MD_UART8  = 2'b01,
    MD_UART9F = 2'b10,
    MD_UART9V = 2'b11
  } sp_mode_e;

  localparam int unsigned OVS      = 16;  // samples per async bit
  localparam int unsigned VOTE_MID = 8;   // centre of the three-sample vote
endpackage

// File: rtl/sport_rate.sv
module sport_rate
  import sport_pkg::*;
#(
  parameter int unsigned M2_DIV = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sp_mode_e mode_i,
  input  logic     smod_i,
  input  logic     baud_tick_i,
  output logic     s_tick_o
);
  localparam int unsigned SUB = M2_DIV / OVS;
  localparam int unsigned CW  = $clog2(SUB) + 1;

  logic [CW-1:0] cnt_q, lim;
  logic          half_q, fixed;

  assign fixed = (mode_i == MD_UART9F);
  assign lim   = smod_i ? CW'(SUB / 2 - 1) : CW'(SUB - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q <= (fixed && cnt_q < lim) ? cnt_q + 1'b1 : '0;
      if (baud_tick_i) half_q <= ~half_q;
    end
  end

  assign s_tick_o = fixed ? (cnt_q >= lim) : (baud_tick_i && (smod_i || half_q));

  AST_FIXED_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fixed && s_tick_o) |=> (!s_tick_o || mode_i != MD_UART9F)); // R4
endmodule

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int unsigned DIV = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tx_start_i,
  input  logic [7:0] data_i,
  input  logic       rx_arm_i,
  input  logic       rxd_i,
  output logic       sclk_o,
  output logic       dout_o,
  output logic       doe_o,
  output logic       ti_set_o,
  output logic       done_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned PW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;

  logic          act_q, is_tx_q, done_q, last_ph;
  logic [PW-1:0] ph_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  assign last_ph  = (ph_q == PW'(DIV - 1));
  assign ti_set_o = en_i && act_q && is_tx_q && last_ph && (bit_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; is_tx_q <= 1'b0; done_q <= 1'b0;
      ph_q <= '0; bit_q <= '0; sh_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        act_q <= 1'b0;
      end else if (tx_start_i) begin
        act_q <= 1'b1; is_tx_q <= 1'b1; ph_q <= '0; bit_q <= '0; sh_q <= data_i;
      end else if (!act_q) begin
        // done_q blocks a restart in the cycle before the receive flag lands
        if (rx_arm_i && !done_q) begin
          act_q <= 1'b1; is_tx_q <= 1'b0; ph_q <= '0; bit_q <= '0;
        end
      end else begin
        ph_q <= last_ph ? '0 : ph_q + 1'b1;
        if (!is_tx_q && ph_q == PW'(HALF - 1)) sh_q <= {rxd_i, sh_q[7:1]};
        if (last_ph) begin
          bit_q <= bit_q + 3'd1;
          if (is_tx_q) sh_q <= {1'b0, sh_q[7:1]};
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= !is_tx_q;
          end
        end
      end
    end
  end

  assign sclk_o  = !act_q || (ph_q >= PW'(HALF));
  assign dout_o  = !(act_q && is_tx_q) || sh_q[0];
  assign doe_o   = en_i && act_q && is_tx_q;
  assign done_o  = done_q;
  assign rdata_o = sh_q;

  AST_SYNC_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R13
endmodule

// File: rtl/sport_utx.sv
module sport_utx
  import sport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       nine_i,
  input  logic       tb8_i,
  input  logic       s_tick_i,
  output logic       txd_o,
  output logic       ti_set_o
);
  logic        busy_q, bit_end;
  logic [10:0] sh_q;
  logic [3:0]  bit_q, sub_q, last_q;

  assign bit_end  = en_i && busy_q && s_tick_i && (sub_q == 4'(OVS - 1));
  assign ti_set_o = bit_end && (bit_q == last_q - 4'd1);
  assign txd_o    = !busy_q || sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; sh_q <= '1; bit_q <= '0; sub_q <= '0; last_q <= 4'd9;
    end else if (start_i && en_i) begin
      busy_q <= 1'b1;
      sub_q  <= '0;
      bit_q  <= '0;
      last_q <= nine_i ? 4'd10 : 4'd9;
      sh_q   <= {1'b1, nine_i ? tb8_i : 1'b1, data_i, 1'b0};
    end else if (!en_i) begin
      busy_q <= 1'b0;
    end else if (busy_q && s_tick_i) begin
      sub_q <= sub_q + 4'd1;
      if (bit_end) begin
        bit_q <= bit_q + 4'd1;
        sh_q  <= {1'b1, sh_q[10:1]};
        if (bit_q == last_q) busy_q <= 1'b0;
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !txd_o); // R2
endmodule

// File: rtl/sport_urx.sv
module sport_urx
  import sport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       nine_i,
  input  logic       s_tick_i,
  input  logic       rxd_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       rb8_o
);
  logic       s1_q, s2_q, s3_q, busy_q, v7_q, v8_q, done_q, rb8_q, maj;
  logic [3:0] sub_q, bit_q, last;
  logic [8:0] sh_q;
  logic [7:0] data_q;

  assign maj  = (v7_q & v8_q) | (v7_q & s2_q) | (v8_q & s2_q);
  assign last = nine_i ? 4'd10 : 4'd9;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1; s2_q <= 1'b1; s3_q <= 1'b1;
      busy_q <= 1'b0; v7_q <= 1'b1; v8_q <= 1'b1; done_q <= 1'b0; rb8_q <= 1'b0;
      sub_q <= '0; bit_q <= '0; sh_q <= '0; data_q <= '0;
    end else begin
      s1_q   <= rxd_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      done_q <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        if (s3_q && !s2_q) begin
          busy_q <= 1'b1; sub_q <= '0; bit_q <= '0;
        end
      end else if (s_tick_i) begin
        sub_q <= sub_q + 4'd1;
        if (sub_q == 4'(VOTE_MID - 1)) v7_q <= s2_q;
        if (sub_q == 4'(VOTE_MID))     v8_q <= s2_q;
        if (sub_q == 4'(VOTE_MID + 1)) begin
          if (bit_q == 4'd0 && maj) begin
            busy_q <= 1'b0;  // false start
          end else if (bit_q == last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            rb8_q  <= nine_i ? sh_q[8] : maj;
            data_q <= nine_i ? sh_q[7:0] : sh_q[8:1];
          end else if (bit_q != 4'd0) begin
            sh_q <= {maj, sh_q[8:1]};
          end
        end
        if (sub_q == 4'(OVS - 1)) bit_q <= bit_q + 4'd1;
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign rb8_o  = rb8_q;

  AST_RX_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(en_i)); // R10
  AST_RX_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
endmodule

// File: rtl/sport_engine.sv
module sport_engine
  import sport_pkg::*;
#(
  parameter int unsigned M0_DIV = 12,
  parameter int unsigned M2_DIV = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_o,
  input  logic       dat_we_i,
  input  logic [7:0] dat_wdata_i,
  output logic [7:0] dat_o,
  input  logic       smod_i,
  input  logic       baud_tick_i,
  input  logic       rxd_i,
  output logic       rxd_o,
  output logic       rxd_oe_o,
  output logic       txd_o,
  output logic       irq_o
);
  logic [1:0] mode_bits_q;
  sp_mode_e   mode;
  logic       sm2_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [7:0] rbuf_q;
  logic       is_m0, nine, s_tick;
  logic       m0_sclk, m0_ti, m0_done;
  logic [7:0] m0_data;
  logic       u_txd, u_ti, u_done, u_rb8, u_accept;
  logic [7:0] u_data;

  assign mode  = sp_mode_e'(mode_bits_q);
  assign is_m0 = (mode == MD_SHIFT);
  assign nine  = (mode == MD_UART9F) || (mode == MD_UART9V);

  sport_rate #(.M2_DIV(M2_DIV)) u_rate (
    .clk_i, .rst_ni, .mode_i(mode), .smod_i, .baud_tick_i, .s_tick_o(s_tick)
  );

  sport_sync #(.DIV(M0_DIV)) u_sync (
    .clk_i, .rst_ni, .en_i(is_m0), .tx_start_i(dat_we_i), .data_i(dat_wdata_i),
    .rx_arm_i(ren_q && !ri_q), .rxd_i, .sclk_o(m0_sclk), .dout_o(rxd_o),
    .doe_o(rxd_oe_o), .ti_set_o(m0_ti), .done_o(m0_done), .rdata_o(m0_data)
  );

  sport_utx u_utx (
    .clk_i, .rst_ni, .en_i(!is_m0), .start_i(dat_we_i), .data_i(dat_wdata_i),
    .nine_i(nine), .tb8_i(tb8_q), .s_tick_i(s_tick), .txd_o(u_txd), .ti_set_o(u_ti)
  );

  sport_urx u_urx (
    .clk_i, .rst_ni, .en_i(!is_m0 && ren_q), .nine_i(nine), .s_tick_i(s_tick),
    .rxd_i, .done_o(u_done), .data_o(u_data), .rb8_o(u_rb8)
  );

  // rb8 holds the stop bit in mode 1 and the ninth bit otherwise, so one test serves the filter
  assign u_accept = u_done && !ri_q && (!sm2_q || u_rb8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_bits_q <= '0; sm2_q <= 1'b0; ren_q <= 1'b0; tb8_q <= 1'b0;
      rb8_q <= 1'b0; ti_q <= 1'b0; ri_q <= 1'b0; rbuf_q <= '0;
    end else begin
      if (ctl_we_i) begin
        mode_bits_q <= ctl_wdata_i[7:6];
        sm2_q       <= ctl_wdata_i[5];
        ren_q       <= ctl_wdata_i[4];
        tb8_q       <= ctl_wdata_i[3];
        rb8_q       <= ctl_wdata_i[2];
        ti_q        <= ctl_wdata_i[1];
        ri_q        <= ctl_wdata_i[0];
      end
      if (m0_ti || u_ti) ti_q <= 1'b1;
      if (u_accept) begin
        rbuf_q <= u_data;
        rb8_q  <= u_rb8;
        ri_q   <= 1'b1;
      end else if (m0_done) begin
        rbuf_q <= m0_data;
        ri_q   <= 1'b1;
      end
    end
  end

  assign txd_o = is_m0 ? m0_sclk : u_txd;
  assign ctl_o = {mode_bits_q, sm2_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign dat_o = rbuf_q;
  assign irq_o = ti_q || ri_q;

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(u_done) && !$past(m0_done)) |-> $stable(rbuf_q)); // R11
  AST_OE_SHIFT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxd_oe_o |-> (mode_bits_q == 2'b00)); // R12
  AST_TI_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({m0_ti, u_ti})); // R5
endmodule

// File: tb/sport_engine_bench.sv
module sport_engine_bench;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       ctl_we = 1'b0, dat_we = 1'b0, smod = 1'b1, tick = 1'b1, rxd_i = 1'b1;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic [7:0] ctl_o, dat_o;
  logic       rxd_o, rxd_oe_o, txd_o, irq_o;
  int         n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  sport_engine u_sport_engine (
    .clk_i(clk), .rst_ni, .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_o,
    .dat_we_i(dat_we), .dat_wdata_i(dat_wdata), .dat_o, .smod_i(smod),
    .baud_tick_i(tick), .rxd_i, .rxd_o, .rxd_oe_o, .txd_o, .irq_o
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  // samples txd at each mid-bit; call right after wr_dat returns
  task automatic chk_tx(input string rq, input int nb, input logic [10:0] fr, input int cpb);
    repeat (cpb / 2) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      if (k > 0) repeat (cpb) @(negedge clk);
      chk(rq, txd_o, fr[k]);
      if (k == nb - 2) chk("R5 ti before stop", ctl_o[1], 1'b0);
      if (k == nb - 1) chk("R5 ti at stop", ctl_o[1], 1'b1);
    end
    repeat (cpb) @(negedge clk);
    chk("R5 irq", irq_o, 1'b1);
  endtask

  task automatic send(input int nb, input logic [10:0] fr, input int cpb, input int gbit);
    for (int k = 0; k < nb; k++)
      for (int c = 0; c < cpb; c++) begin
        @(negedge clk);
        rxd_i = (k == gbit && c == 9) ? ~fr[k] : fr[k];
      end
    @(negedge clk); rxd_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl_o, 8'h00);
    chk("R1 txd", txd_o, 1'b1);
    chk("R1 rxd_o", rxd_o, 1'b1);
    chk("R1 oe", rxd_oe_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);

    // R2 mode 01, doubled rate: 16 clocks per bit
    wr_ctl(8'h40);
    foreach (pats[i]) begin
      wr_dat(pats[i]);
      chk_tx("R2 mode1 frame", 10, {1'b1, 1'b1, pats[i], 1'b0}, 16);
      wr_ctl(8'h40);
      chk("R5 flag cleared", irq_o, 1'b0);
    end
    // R2 undoubled: every second tick, 32 clocks per bit
    smod = 1'b0;
    wr_dat(8'h6B);
    chk_tx("R2 mode1 half rate", 10, {2'b11, 8'h6B, 1'b0}, 32);
    smod = 1'b1;

    // R3 mode 11 ninth bit from bit 3
    for (int t = 0; t < 2; t++) begin
      wr_ctl(t[0] ? 8'hC8 : 8'hC0);
      wr_dat(t[0] ? 8'hC3 : 8'h5A);
      chk_tx("R3 mode3 frame", 11, {1'b1, t[0], t[0] ? 8'hC3 : 8'h5A, 1'b0}, 16);
    end

    // R4 mode 10 fixed rates
    wr_ctl(8'h88);
    wr_dat(8'h96);
    chk_tx("R4 mode2 smod1", 11, {2'b11, 8'h96, 1'b0}, 32);
    wr_ctl(8'h88);
    smod = 1'b0;
    wr_dat(8'h29);
    chk_tx("R4 mode2 smod0", 11, {2'b11, 8'h29, 1'b0}, 64);
    smod = 1'b1;

    // R6 mode 01 receive
    for (int i = 0; i < 3; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'h55 : 8'hE7;
      wr_ctl(8'h50);
      send(10, {2'b11, b, 1'b0}, 16, -1);
      chk("R6 data", dat_o, b);
      chk("R6 ri", ctl_o[0], 1'b1);
      chk("R6 rb8 stop", ctl_o[2], 1'b1);
    end

    // R7 filter in mode 01: bad stop dropped, good stop kept
    wr_ctl(8'h74);
    send(10, {2'b10, 8'h12, 1'b0}, 16, -1);
    chk("R7 no ri", ctl_o[0], 1'b0);
    chk("R7 buf kept", dat_o, 8'hE7);
    chk("R7 rb8 kept", ctl_o[2], 1'b1);
    send(10, {2'b11, 8'h34, 1'b0}, 16, -1);
    chk("R7 ri", ctl_o[0], 1'b1);
    chk("R7 data", dat_o, 8'h34);

    // R8 filter in mode 11
    wr_ctl(8'hF4);
    send(11, {1'b1, 1'b0, 8'h77, 1'b0}, 16, -1);
    chk("R8 data frame ignored", ctl_o[0], 1'b0);
    chk("R8 buf kept", dat_o, 8'h34);
    chk("R8 rb8 kept", ctl_o[2], 1'b1);
    wr_ctl(8'hF0);
    send(11, {1'b1, 1'b1, 8'hA1, 1'b0}, 16, -1);
    chk("R8 address ri", ctl_o[0], 1'b1);
    chk("R8 address data", dat_o, 8'hA1);
    chk("R8 rb8 ninth", ctl_o[2], 1'b1);
    wr_ctl(8'hD4);
    send(11, {1'b0, 1'b0, 8'h0F, 1'b0}, 16, -1);  // stop 0 must be ignored
    chk("R8 unfiltered ri", ctl_o[0], 1'b1);
    chk("R8 unfiltered data", dat_o, 8'h0F);
    chk("R8 rb8 zero", ctl_o[2], 1'b0);

    // R4 mode 10 receive at 64 clocks per bit
    smod = 1'b0;
    wr_ctl(8'hB0);
    send(11, {1'b1, 1'b1, 8'hC6, 1'b0}, 64, -1);
    chk("R4 mode2 rx ri", ctl_o[0], 1'b1);
    chk("R4 mode2 rx data", dat_o, 8'hC6);
    smod = 1'b1;

    // R11 overrun
    wr_ctl(8'h50);
    send(10, {2'b11, 8'h11, 1'b0}, 16, -1);
    send(10, {2'b11, 8'h22, 1'b0}, 16, -1);
    chk("R11 first kept", dat_o, 8'h11);
    chk("R11 ri", ctl_o[0], 1'b1);

    // R9 false start, then a glitch on the centre sample of data bit 3
    wr_ctl(8'h50);
    @(negedge clk); rxd_i = 1'b0;
    repeat (4) @(negedge clk);
    rxd_i = 1'b1;
    repeat (200) @(negedge clk);
    chk("R9 false start", ctl_o[0], 1'b0);
    chk("R9 buf kept", dat_o, 8'h11);
    send(10, {2'b11, 8'h6D, 1'b0}, 16, 4);
    chk("R9 vote ri", ctl_o[0], 1'b1);
    chk("R9 vote data", dat_o, 8'h6D);

    // R10 receive disabled
    wr_ctl(8'h40);
    send(10, {2'b11, 8'h99, 1'b0}, 16, -1);
    chk("R10 no ri", ctl_o[0], 1'b0);
    chk("R10 buf kept", dat_o, 8'h6D);

    // R12 mode 00 transmit
    for (int t = 0; t < 2; t++) begin
      logic [7:0] b;
      b = t[0] ? 8'h01 : 8'hB4;
      wr_ctl(8'h00);
      wr_dat(b);
      repeat (3) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        if (k > 0) repeat (6) @(negedge clk);
        chk("R12 data", rxd_o, b[k]);
        chk("R12 oe", rxd_oe_o, 1'b1);
        chk("R12 clk low", txd_o, 1'b0);
        repeat (6) @(negedge clk);
        chk("R12 clk high", txd_o, 1'b1);
      end
      repeat (4) @(negedge clk);
      chk("R12 oe off", rxd_oe_o, 1'b0);
      chk("R5 mode0 ti", ctl_o[1], 1'b1);
    end

    // R13 mode 00 receive
    begin
      logic [7:0] b;
      b = 8'h9C;
      wr_ctl(8'h10);
      for (int k = 0; k < 8; k++) begin
        @(negedge txd_o);
        rxd_i = b[k];
      end
      repeat (20) @(negedge clk);
      rxd_i = 1'b1;
      chk("R13 ri", ctl_o[0], 1'b1);
      chk("R13 data", dat_o, b);
      repeat (30) @(negedge clk);
      chk("R13 stopped", txd_o, 1'b1);
    end

    summary();
  end
endmodule